// File: doc/BRIEF.md
# Non-pipelined processor bus cycle controller

This block runs a processor-side external bus for single read and write transfers. A core presents a request with an address, a direction flag and, for writes, the data. The controller takes the request when the bus can start a new transfer. It then steps the bus through an address state and a data state and returns a one-clock completion pulse. For a read, the data captured from the bus comes back with that pulse. Address timing is non-pipelined: each transfer puts its address out at the start of its own address state.

The controller runs from a clock at twice the bus-state rate, so every bus state lasts two clocks: a first phase and a second phase. The states are idle, address and data. A transfer with no wait states takes one address state and one data state. The external device stretches the data state by holding ready low at its end. A pending request may start straight after a finished data state, with no idle state between. Write data appears in the second phase of the address state. It stays on the bus, unchanged, for the first phase of the state that follows the acknowledge. During reads the controller releases the shared data lines.

Top module: `nbus_ctrl`

## Requirements
- R1: While rst_n is low the controller is idle in the first phase: bus_strobe is 0, done is 0, req_accept is 0 even with req_valid high, and the data lines are released.
- R2: Every bus state lasts exactly two clocks. The state changes only at the end of the second phase.
- R3: bus_strobe is 1 for exactly the two clocks of the address state. bus_addr and bus_wr (1 = write, 0 = read) carry the accepted request from the start of the address state and stay unchanged until the cycle ends.
- R4: req_accept is 1 only in the second phase of the idle state, or in the second phase of a data state that ready ends. It is never 1 during the address state. The clock edge that accepts a request starts the address state.
- R5: During a read the controller does not drive the data lines in the data state. The external device's value is what reaches the core.
- R6: When bus_ready is 1 at the end of a read's data state, the value on bus_data is stored in rd_data. done is 1 for the next clock.
- R7: For a write the controller drives req_wdata on bus_data from the second phase of the address state until the cycle ends.
- R8: After a write is acknowledged, bus_data keeps the same write value through the first phase of the next bus state.
- R9: If bus_ready is 0 at the end of a data state, the bus stays in the data state for two more clocks and samples ready again. No completion is reported before ready is seen.
- R10: If a request is pending when a data state ends with ready, the next address state follows at once, with no idle state.
- R11: If no request is pending when a data state ends with ready, the bus returns to idle. bus_strobe then stays 0 until a new request is accepted.
- R12: done is a single-clock pulse, once per completed transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock; two clocks per bus state |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core has a transfer request |
| req_write | input | 1 | Request direction, 1 = write |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Request write data |
| req_accept | output | 1 | Request is taken at this clock edge |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | DATA_W | Data captured by the last read |
| bus_strobe | output | 1 | Address strobe, high for the address state |
| bus_wr | output | 1 | Bus direction, 1 = write |
| bus_addr | output | ADDR_W | Bus address |
| bus_data | inout | DATA_W | Shared data lines |
| bus_ready | input | 1 | Device acknowledge, sampled at the end of a data state |

## Verification
On every clock the assertions check several rules: the two-clock state rhythm, the strobe length, address stability, the start of a transfer after acceptance, repeated data states while ready is low, the return to idle, and the single-clock done pulse. They also check the controller's own drive enable: off through a read's data state, on through a write, and held with unchanged data for one phase after a write acknowledge. Only the bench scenarios can show the end-to-end data path. This covers read values coming back intact after neighbouring writes, written values reaching the device model, and the order of back-to-back transfers with mixed directions and wait counts.

// File: rtl/nbus_pkg.sv
package nbus_pkg;
  typedef enum logic [1:0] {
    BS_IDLE = 2'd0,
    BS_ADDR = 2'd1,
    BS_DATA = 2'd2
  } bus_state_e;
endpackage

// File: rtl/nbus_seq.sv
module nbus_seq
  import nbus_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       bus_ready,
  output bus_state_e state,
  output logic       ph_two,
  output logic       accept,
  output logic       ack
);
  bus_state_e state_n;
  logic       ph_n;

  always_comb begin
    state_n = state;
    ph_n    = ~ph_two;
    if (ph_two) begin
      case (state)
        BS_IDLE: if (req_valid) state_n = BS_ADDR;
        BS_ADDR: state_n = BS_DATA;
        BS_DATA: if (bus_ready) state_n = req_valid ? BS_ADDR : BS_IDLE;
        default: state_n = BS_IDLE;
      endcase
    end
  end

  assign ack    = ph_two && (state == BS_DATA) && bus_ready;
  assign accept = ph_two && req_valid && ((state == BS_IDLE) || ((state == BS_DATA) && bus_ready));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= BS_IDLE;
      ph_two <= 1'b0;
    end else begin
      state  <= state_n;
      ph_two <= ph_n;
    end
  end

  // R2: no state change at the end of a first phase
  p_two_clk_state_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ph_two |=> (state == $past(state)));
  // R4: acceptance opens the address state in its first phase
  p_accept_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (state == BS_ADDR) && !ph_two);
  // R4: never accepted during the address state
  p_no_accept_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == BS_ADDR) |-> !accept);
  // R9: missing ready repeats the data state
  p_wait_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_two && (state == BS_DATA) && !bus_ready) |=> (state == BS_DATA) && !ph_two);
  // R11: nothing pending after an acknowledge returns to idle
  p_back_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !req_valid) |=> (state == BS_IDLE));
endmodule

// File: rtl/nbus_wdrv.sv
module nbus_wdrv
  import nbus_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_state_e        state,
  input  logic              ph_two,
  input  logic              ack,
  input  logic              wr_q,
  input  logic [DATA_W-1:0] wdata_q,
  output logic              drv_en,
  output logic [DATA_W-1:0] dout
);
  logic load_pt, drop_pt, drv_en_n, dout_en;

  always_comb begin
    load_pt  = (state == BS_ADDR) && !ph_two;
    drop_pt  = (state == BS_IDLE) && !ph_two;
    drv_en_n = drv_en;
    if (load_pt)      drv_en_n = wr_q;
    else if (drop_pt) drv_en_n = 1'b0;
    dout_en  = load_pt && wr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_en <= 1'b0;
      dout   <= '0;
    end else begin
      drv_en <= drv_en_n;
      if (dout_en) dout <= wdata_q;
    end
  end

  // R5: lines released through a read data state
  p_read_float_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == BS_DATA) && !wr_q) |-> !drv_en);
  // R7: write value on the lines through the data state
  p_write_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == BS_DATA) && wr_q) |-> (drv_en && (dout == wdata_q)));
  // R8: hold for one phase after a write acknowledge
  p_write_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && wr_q) |=> (drv_en && $stable(dout)));
endmodule

// File: rtl/nbus_rdcap.sv
module nbus_rdcap #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack,
  input  logic              wr_q,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] rd_data,
  output logic              done
);
  logic cap_en;

  always_comb cap_en = ack && !wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      done    <= 1'b0;
    end else begin
      done <= ack;
      if (cap_en) rd_data <= bus_in;
    end
  end

  // R6: captured value is the one on the lines at the acknowledge
  p_read_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !wr_q) |=> (rd_data == $past(bus_in)));
  // R12: completion pulse lasts one clock
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/nbus_ctrl.sv
module nbus_ctrl
  import nbus_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_accept,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              bus_strobe,
  output logic              bus_wr,
  output logic [ADDR_W-1:0] bus_addr,
  inout  wire  [DATA_W-1:0] bus_data,
  input  logic              bus_ready
);
  bus_state_e        state;
  logic              ph_two, ack, drv_en;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, dout;

  nbus_seq u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .bus_ready(bus_ready),
    .state(state), .ph_two(ph_two), .accept(req_accept), .ack(ack)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (req_accept) begin
      wr_q    <= req_write;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  nbus_wdrv #(.DATA_W(DATA_W)) u_wdrv (
    .clk(clk), .rst_n(rst_n), .state(state), .ph_two(ph_two), .ack(ack),
    .wr_q(wr_q), .wdata_q(wdata_q), .drv_en(drv_en), .dout(dout)
  );

  nbus_rdcap #(.DATA_W(DATA_W)) u_rdcap (
    .clk(clk), .rst_n(rst_n), .ack(ack), .wr_q(wr_q), .bus_in(bus_data),
    .rd_data(rd_data), .done(done)
  );

  assign bus_data   = drv_en ? dout : {DATA_W{1'bz}};
  assign bus_strobe = (state == BS_ADDR);
  assign bus_wr     = wr_q;
  assign bus_addr   = addr_q;

  // R3: strobe high for two clocks, then low
  p_strobe_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_strobe) |=> bus_strobe ##1 !bus_strobe);
  // R3: address and direction steady from address state to cycle end
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_strobe && ph_two) || (state == BS_DATA)) |-> ($stable(bus_addr) && $stable(bus_wr)));
  // R10: pending request starts the next address state without idle
  p_chain_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && req_valid) |=> bus_strobe);
endmodule

// File: tb/nbus_ctrl_test.sv
module nbus_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 16;

  typedef struct {
    logic          wr;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    int            waits;
  } xfer_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          req_accept, done, bus_strobe, bus_wr, bus_ready;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] bus_addr;
  wire  [DW-1:0] bus_data;
  logic          rsp_drive;
  logic [DW-1:0] rsp_val;
  logic          acc_seen;

  int n_checks = 0;
  int n_fail = 0;
  xfer_t bus_q[$];
  xfer_t done_q[$];
  logic [DW-1:0] bus_mem [16];
  logic [DW-1:0] exp_mem [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign bus_data = rsp_drive ? rsp_val : {DW{1'bz}};

  nbus_ctrl #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_accept(req_accept),
    .done(done), .rd_data(rd_data), .bus_strobe(bus_strobe), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_data(bus_data), .bus_ready(bus_ready)
  );

  always @(posedge clk) acc_seen <= req_accept;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_xfer(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d, input int waits);
    xfer_t it;
    it.wr = wr; it.addr = a; it.waits = waits;
    if (wr) begin
      it.data = d;
      exp_mem[a[3:0]] = d;
    end else begin
      it.data = exp_mem[a[3:0]];
    end
    bus_q.push_back(it);
    done_q.push_back(it);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    do begin
      @(posedge clk); #1;
    end while (!acc_seen);
  endtask

  task automatic stop_req();
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    while (done_q.size() > 0) @(posedge clk);
    #1;
  endtask

  task automatic idle_check(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(!bus_strobe && !done, "R11 idle bus stays quiet", {30'd0, bus_strobe, done}, 32'd0);
    end
  endtask

  // bus-side device model and timing checks
  initial begin : responder
    xfer_t it;
    bit at_t1;
    int w;
    at_t1 = 1'b0; rsp_drive = 1'b0; rsp_val = '0; bus_ready = 1'b0;
    wait (rst_n === 1'b1);
    forever begin
      if (!at_t1) @(negedge clk);
      at_t1 = 1'b0;
      if (bus_strobe) begin
        if (bus_q.size() == 0) begin
          check(1'b0, "R3 strobe without request", 32'd1, 32'd0);
          continue;
        end
        it = bus_q.pop_front();
        check((bus_addr == it.addr) && (bus_wr == it.wr), "R3 address and direction at T1",
              {23'd0, bus_wr, bus_addr}, {23'd0, it.wr, it.addr});
        @(negedge clk);
        check(bus_strobe, "R3 strobe in second phase", {31'd0, bus_strobe}, 32'd1);
        if (it.wr) check(bus_data == it.data, "R7 write data in T1 phase two", {16'd0, bus_data}, {16'd0, it.data});
        w = 0;
        forever begin
          @(negedge clk);
          check(!bus_strobe && !done, "R9 data state quiet before ready", {30'd0, bus_strobe, done}, 32'd0);
          if (!it.wr) begin
            rsp_drive = 1'b1;
            rsp_val = bus_mem[it.addr[3:0]];
          end
          @(negedge clk);
          check(!bus_strobe, "R2 data state second phase", {31'd0, bus_strobe}, 32'd0);
          if (it.wr) check(bus_data == it.data, "R7 write data in T2", {16'd0, bus_data}, {16'd0, it.data});
          bus_ready = (w >= it.waits);
          if (bus_ready) break;
          w++;
        end
        if (it.wr) bus_mem[it.addr[3:0]] = bus_data;
        @(negedge clk);
        bus_ready = 1'b0;
        rsp_drive = 1'b0;
        check(done, "R6 done one clock after ready", {31'd0, done}, 32'd1);
        if (it.wr) check(bus_data == it.data, "R8 write hold after acknowledge", {16'd0, bus_data}, {16'd0, it.data});
        if (bus_q.size() > 0) begin
          check(bus_strobe, "R10 chained T1 follows T2", {31'd0, bus_strobe}, 32'd1);
          at_t1 = 1'b1;
        end else begin
          check(!bus_strobe, "R11 return to idle", {31'd0, bus_strobe}, 32'd0);
        end
      end
    end
  end

  // scoreboard monitor on completions
  logic prev_done;
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (req_accept && bus_strobe) check(1'b0, "R4 accept during address state", 32'd1, 32'd0);
      if (done && prev_done) check(1'b0, "R12 done longer than one clock", 32'd2, 32'd1);
      if (done) begin
        if (done_q.size() == 0) begin
          check(1'b0, "R12 done without transfer", 32'd1, 32'd0);
        end else begin
          xfer_t it;
          it = done_q.pop_front();
          if (!it.wr) check(rd_data == it.data, "R6 R5 read data returned", {16'd0, rd_data}, {16'd0, it.data});
          else check(bus_mem[it.addr[3:0]] == it.data, "R7 write reached device",
                     {16'd0, bus_mem[it.addr[3:0]]}, {16'd0, it.data});
        end
      end
    end
    prev_done = done;
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < 16; i++) begin
      bus_mem[i] = 16'h1000 + 16'(i) * 16'h0101;
      exp_mem[i] = 16'h1000 + 16'(i) * 16'h0101;
    end
    prev_done = 1'b0;
    rst_n = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    check(!bus_strobe, "R1 strobe low in reset", {31'd0, bus_strobe}, 32'd0);
    check(!done, "R1 done low in reset", {31'd0, done}, 32'd0);
    check(!req_accept, "R1 no accept in reset", {31'd0, req_accept}, 32'd0);
    req_valid = 1'b0;
    rst_n = 1'b1;
    idle_check(6);

    do_xfer(1'b1, 8'h03, 16'hBEEF, 0); stop_req(); wait_done();
    do_xfer(1'b0, 8'h03, 16'h0000, 0); stop_req(); wait_done();
    do_xfer(1'b0, 8'h05, 16'h0000, 0); stop_req(); wait_done();
    do_xfer(1'b1, 8'h07, 16'h1357, 2); stop_req(); wait_done();
    do_xfer(1'b0, 8'h07, 16'h0000, 1); stop_req(); wait_done();
    idle_check(5);

    do_xfer(1'b1, 8'h09, 16'hA5A5, 0);
    do_xfer(1'b1, 8'h0A, 16'h5A5A, 0);
    do_xfer(1'b0, 8'h09, 16'h0000, 0);
    do_xfer(1'b0, 8'h0A, 16'h0000, 1);
    do_xfer(1'b1, 8'h09, 16'h0F0F, 1);
    do_xfer(1'b0, 8'h09, 16'h0000, 0);
    do_xfer(1'b0, 8'h02, 16'h0000, 3);
    stop_req();
    wait_done();
    idle_check(4);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule